// File: doc/BRIEF.md
# Byte-Wide Flash Job Master

This block is the host side of a byte-wide parallel flash bus. It receives one job at a time on a valid/ready request port. A job is a byte program, a sector erase, a whole-chip erase or an identification read. The block turns each job into the unlock write cycles the flash expects and drives chip enable, output enable, write enable, the address and the data bus. When a program or erase job is in its polling phase, the block reads the flash repeatedly until the busy indication stops toggling. It then reports completion with a one-cycle done pulse, the last byte read and a timeout flag.

All strobe timing is counted in clock cycles and set by parameters. The integrator picks the counts that meet the flash's nanosecond limits at the clock in use. The defaults suit a 50 MHz clock:
- a write-enable low pulse of 100 ns;
- a write-enable high recovery of 100 ns;
- a 40 ns read access window;
- a 10 µs identification pause;
- a 0.2 s erase timeout.

An identification job ends by writing the exit command, so the flash is back in array-read mode when done is reported.

Top module: `pflash_job_master`

## Requirements
- R1: After reset, and at any time when no job is in progress, `req_ready` is 1, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0 and `done_valid` is 0.
- R2: Job code 0 (program) produces exactly four write pulses, in this order: 0xAA to address 0x5555, 0x55 to address 0x2AAA, 0xA0 to 0x5555, then `req_data` to `req_addr`.
- R3: Job codes 1 (sector erase) and 2 (chip erase) produce exactly six write pulses, in this order:
  - 0xAA to 0x5555, 0x55 to 0x2AAA and 0x80 to 0x5555;
  - 0xAA to 0x5555 and 0x55 to 0x2AAA;
  - a final pulse: 0x30 to `req_addr` for a sector erase, or 0x10 to 0x5555 for a chip erase.
- R4: Each write-enable low pulse lasts exactly WE_LOW_CYC clocks. Write enable stays high for at least WE_HIGH_CYC clocks between two pulses.
- R5: While write enable is low, `fl_addr` and `fl_dq_out` do not change. On the clock where write enable rises, the data bus is still driven with the same byte.
- R6: Output enable is high whenever write enable is low. The data bus driver `fl_dq_oe` is off whenever output enable is low.
- R7: A read holds output enable low for OE_CYC clocks. The read byte is the value of `fl_dq_in` during the last of those clocks.
- R8: After its last write, a program or erase job reads `req_addr` repeatedly. The job completes on the first read whose bit 6 equals bit 6 of the read just before it. At that point `done_valid` pulses for one clock, `done_timeout` is 0 and `done_data` holds that read byte.
- R9: If bit 6 is still toggling once TIMEOUT_CYC clocks have passed since polling began, the job ends after the current read with `done_timeout` set to 1.
- R10: Job code 3 (identify) performs these steps in order:
  - writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0x90 to 0x5555;
  - keeps the bus idle for at least ID_WAIT_CYC clocks;
  - reads `req_addr` once;
  - writes 0xF0 to address 0;
  - completes with `done_data` equal to the byte it read.
- R11: A request is taken only while `req_ready` is 1. `req_ready` stays 0 for the whole job. Request inputs that change while a job is running do not change that job's bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Job request present |
| req_ready | output | 1 | Master idle, request accepted this cycle if valid |
| req_op | input | 2 | Job code: 0 program, 1 sector erase, 2 chip erase, 3 identify |
| req_addr | input | AW | Target, sector or identification address |
| req_data | input | 8 | Byte to program |
| done_valid | output | 1 | One-cycle completion pulse |
| done_timeout | output | 1 | Job ended because polling timed out |
| done_data | output | 8 | Last byte read by the job |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enables the data bus driver |
| fl_dq_in | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
A wrong step counter or job decode would show up at the next rising edge of write enable: an unlock byte or address would appear out of order in the captured write stream. A wrong strobe counter would also be caught at that edge, through a pulse of the wrong length, moving data or a driven bus during a read. A fault in the poll comparison appears only when the job ends: the number of reads differs from the count predicted by the flash model's toggle pattern. A timeout fault is only visible at the end of the TIMEOUT_CYC window.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_SECT  = 2'd1,
      OP_CHIP  = 2'd2,
      OP_IDENT = 2'd3
   } job_op_t;

   typedef enum logic [2:0] {
      ST_WR,
      ST_RD,
      ST_POLL,
      ST_PAUSE,
      ST_END
   } step_kind_t;

   localparam logic [14:0] UNLOCK_A = 15'h5555;
   localparam logic [14:0] UNLOCK_B = 15'h2AAA;

   localparam logic [7:0] KEY_1      = 8'hAA;
   localparam logic [7:0] KEY_2      = 8'h55;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_ERASE  = 8'h80;
   localparam logic [7:0] CMD_CHIP   = 8'h10;
   localparam logic [7:0] CMD_SECTOR = 8'h30;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_EXIT   = 8'hF0;

endpackage

// File: rtl/pflash_tick.sv
module pflash_tick #(
   parameter int unsigned MAXV = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int unsigned CW = (MAXV < 2) ? 1 : $clog2(MAXV + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CW'(MAXV);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   a_r9_count_down_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(!load) && !$past(expired)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pflash_bus_cycle.sv
module pflash_bus_cycle #(
   parameter int unsigned AW          = 18,
   parameter int unsigned WE_LOW_CYC  = 5,
   parameter int unsigned WE_HIGH_CYC = 5,
   parameter int unsigned OE_CYC      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    wdata_in,
   output logic          done,
   output logic [7:0]    rdata,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dq_out,
   output logic          fl_dq_oe,
   input  logic [7:0]    fl_dq_in,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);
   localparam int unsigned MAX_A = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
   localparam int unsigned MAX_C = (MAX_A > OE_CYC) ? MAX_A : OE_CYC;
   localparam int unsigned CW    = $clog2(MAX_C + 1);

   generate
      if (WE_LOW_CYC < 1 || WE_HIGH_CYC < 1 || OE_CYC < 1) begin : g_bad_timing
         $error("pflash_bus_cycle: strobe counts must be at least one clock");
      end
   endgenerate

   typedef enum logic [2:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_ACC, B_GAP} bus_st_t;

   bus_st_t       st_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] a_q;
   logic [7:0]    d_q;
   logic [7:0]    r_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= B_IDLE;
         cnt_q <= '0;
         a_q   <= '0;
         d_q   <= '0;
         r_q   <= '0;
      end else begin
         unique case (st_q)
            B_IDLE: if (start) begin
               a_q   <= addr_in;
               d_q   <= wdata_in;
               st_q  <= rd ? B_ACC : B_SETUP;
               cnt_q <= rd ? CW'(OE_CYC - 1) : '0;
            end
            B_SETUP: begin
               st_q  <= B_PULSE;
               cnt_q <= CW'(WE_LOW_CYC - 1);
            end
            B_PULSE: if (cnt_q == '0) begin
               st_q  <= B_HOLD;
               cnt_q <= CW'(WE_HIGH_CYC - 1);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            B_HOLD: if (cnt_q == '0) begin
               st_q <= B_IDLE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            B_ACC: if (cnt_q == '0) begin
               r_q  <= fl_dq_in;
               st_q <= B_GAP;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            B_GAP: st_q <= B_IDLE;
            default: st_q <= B_IDLE;
         endcase
      end
   end

   assign done      = ((st_q == B_HOLD) && (cnt_q == '0)) || (st_q == B_GAP);
   assign rdata     = r_q;
   assign fl_addr   = a_q;
   assign fl_dq_out = d_q;
   assign fl_dq_oe  = (st_q == B_SETUP) || (st_q == B_PULSE) || (st_q == B_HOLD);
   assign fl_ce_n   = !(fl_dq_oe || (st_q == B_ACC));
   assign fl_oe_n   = (st_q != B_ACC);
   assign fl_we_n   = (st_q != B_PULSE);

   // checker state for pulse-width properties
   int unsigned low_run;
   int unsigned high_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= 0;
         high_run <= WE_HIGH_CYC;
      end else begin
         low_run  <= fl_we_n ? 0 : low_run + 1;
         high_run <= !fl_we_n ? 0 : ((high_run < WE_HIGH_CYC) ? high_run + 1 : high_run);
      end
   end

   a_r4_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (low_run == WE_LOW_CYC));
   a_r4_we_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> (high_run >= WE_HIGH_CYC));
   a_r5_bus_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
   a_r5_data_held_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> ($stable(fl_dq_out) && fl_dq_oe));
   a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> (fl_oe_n && fl_dq_oe));
   a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_dq_oe);

endmodule

// File: rtl/pflash_job_master.sv
module pflash_job_master
   import pflash_pkg::*;
#(
   parameter int unsigned AW          = 18,
   parameter int unsigned WE_LOW_CYC  = 5,
   parameter int unsigned WE_HIGH_CYC = 5,
   parameter int unsigned OE_CYC      = 2,
   parameter int unsigned ID_WAIT_CYC = 500,
   parameter int unsigned TIMEOUT_CYC = 10_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          done_valid,
   output logic          done_timeout,
   output logic [7:0]    done_data,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dq_out,
   output logic          fl_dq_oe,
   input  logic [7:0]    fl_dq_in,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);
   generate
      if (AW < 16) begin : g_bad_aw
         $error("pflash_job_master: AW must cover the 15-bit unlock addresses");
      end
      if (ID_WAIT_CYC < 1 || TIMEOUT_CYC < 1) begin : g_bad_wait
         $error("pflash_job_master: wait counts must be at least one clock");
      end
   endgenerate

   typedef struct packed {
      step_kind_t    kind;
      logic [AW-1:0] addr;
      logic [7:0]    data;
   } step_t;

   typedef enum logic [2:0] {T_IDLE, T_ISSUE, T_WAIT, T_PAUSE, T_FIN} job_st_t;

   localparam logic [AW-1:0] ADR_A = {{(AW-15){1'b0}}, UNLOCK_A};
   localparam logic [AW-1:0] ADR_B = {{(AW-15){1'b0}}, UNLOCK_B};

   function automatic step_t plan_step(job_op_t op, logic [2:0] s,
                                       logic [AW-1:0] a, logic [7:0] d);
      step_t r;
      r.kind = ST_END;
      r.addr = '0;
      r.data = '0;
      if (s == 3'd0) begin
         r.kind = ST_WR; r.addr = ADR_A; r.data = KEY_1;
      end else if (s == 3'd1) begin
         r.kind = ST_WR; r.addr = ADR_B; r.data = KEY_2;
      end else begin
         unique case (op)
            OP_PROG: unique case (s)
               3'd2: begin r.kind = ST_WR;   r.addr = ADR_A; r.data = CMD_PROG; end
               3'd3: begin r.kind = ST_WR;   r.addr = a;     r.data = d;        end
               3'd4: begin r.kind = ST_POLL; r.addr = a;                        end
               default: r.kind = ST_END;
            endcase
            OP_SECT, OP_CHIP: unique case (s)
               3'd2: begin r.kind = ST_WR; r.addr = ADR_A; r.data = CMD_ERASE; end
               3'd3: begin r.kind = ST_WR; r.addr = ADR_A; r.data = KEY_1;     end
               3'd4: begin r.kind = ST_WR; r.addr = ADR_B; r.data = KEY_2;     end
               3'd5: begin
                  r.kind = ST_WR;
                  r.addr = (op == OP_CHIP) ? ADR_A : a;
                  r.data = (op == OP_CHIP) ? CMD_CHIP : CMD_SECTOR;
               end
               3'd6: begin r.kind = ST_POLL; r.addr = a; end
               default: r.kind = ST_END;
            endcase
            OP_IDENT: unique case (s)
               3'd2: begin r.kind = ST_WR;    r.addr = ADR_A; r.data = CMD_IDENT; end
               3'd3: begin r.kind = ST_PAUSE;                                     end
               3'd4: begin r.kind = ST_RD;    r.addr = a;                         end
               3'd5: begin r.kind = ST_WR;    r.addr = '0;    r.data = CMD_EXIT;  end
               default: r.kind = ST_END;
            endcase
            default: r.kind = ST_END;
         endcase
      end
      return r;
   endfunction

   job_st_t       st_q;
   job_op_t       op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic [2:0]    step_q;
   logic          prev6_q;
   logic          have_prev_q;
   logic [7:0]    res_data_q;
   logic          res_tmo_q;

   step_t      cur;
   logic       cyc_start;
   logic       cyc_done;
   logic [7:0] cyc_rdata;
   logic       tmo_load;
   logic       tmo_expired;
   logic       pause_load;
   logic       pause_expired;

   assign cur        = plan_step(op_q, step_q, addr_q, data_q);
   assign cyc_start  = (st_q == T_ISSUE) &&
                       ((cur.kind == ST_WR) || (cur.kind == ST_RD) || (cur.kind == ST_POLL));
   assign tmo_load   = (st_q == T_ISSUE) && (cur.kind == ST_POLL) && !have_prev_q;
   assign pause_load = (st_q == T_ISSUE) && (cur.kind == ST_PAUSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= T_IDLE;
         op_q        <= OP_PROG;
         addr_q      <= '0;
         data_q      <= '0;
         step_q      <= '0;
         prev6_q     <= 1'b0;
         have_prev_q <= 1'b0;
         res_data_q  <= '0;
         res_tmo_q   <= 1'b0;
      end else begin
         unique case (st_q)
            T_IDLE: if (req_valid) begin
               op_q        <= job_op_t'(req_op);
               addr_q      <= req_addr;
               data_q      <= req_data;
               step_q      <= '0;
               have_prev_q <= 1'b0;
               res_tmo_q   <= 1'b0;
               st_q        <= T_ISSUE;
            end
            T_ISSUE: unique case (cur.kind)
               ST_PAUSE: st_q <= T_PAUSE;
               ST_END:   st_q <= T_FIN;
               default:  st_q <= T_WAIT;
            endcase
            T_PAUSE: if (pause_expired) begin
               step_q <= step_q + 1'b1;
               st_q   <= T_ISSUE;
            end
            T_WAIT: if (cyc_done) begin
               if (cur.kind == ST_POLL) begin
                  res_data_q <= cyc_rdata;
                  if (have_prev_q && (cyc_rdata[6] == prev6_q)) begin
                     st_q <= T_FIN;
                  end else if (tmo_expired) begin
                     res_tmo_q <= 1'b1;
                     st_q      <= T_FIN;
                  end else begin
                     prev6_q     <= cyc_rdata[6];
                     have_prev_q <= 1'b1;
                     st_q        <= T_ISSUE;
                  end
               end else begin
                  if (cur.kind == ST_RD) res_data_q <= cyc_rdata;
                  step_q <= step_q + 1'b1;
                  st_q   <= T_ISSUE;
               end
            end
            T_FIN:   st_q <= T_IDLE;
            default: st_q <= T_IDLE;
         endcase
      end
   end

   assign req_ready    = (st_q == T_IDLE);
   assign done_valid   = (st_q == T_FIN);
   assign done_timeout = res_tmo_q;
   assign done_data    = res_data_q;

   pflash_bus_cycle #(
      .AW(AW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC), .OE_CYC(OE_CYC)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .start(cyc_start), .rd(cur.kind != ST_WR),
      .addr_in(cur.addr), .wdata_in(cur.data), .done(cyc_done), .rdata(cyc_rdata),
      .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
      .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
   );

   pflash_tick #(.MAXV(TIMEOUT_CYC)) u_timeout (
      .clk(clk), .rst_n(rst_n), .load(tmo_load), .expired(tmo_expired)
   );

   pflash_tick #(.MAXV(ID_WAIT_CYC)) u_pause (
      .clk(clk), .rst_n(rst_n), .load(pause_load), .expired(pause_expired)
   );

   a_r1_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));
   a_r11_no_bus_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> fl_ce_n);
   a_r8_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));
   a_r10_pause_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == T_PAUSE) |-> (fl_ce_n && fl_we_n));

endmodule

// File: tb/pflash_job_master_test.sv
module pflash_job_master_test;

   localparam int AW      = 18;
   localparam int WE_LOW  = 5;
   localparam int WE_HIGH = 5;
   localparam int OE_C    = 2;
   localparam int ID_WAIT = 500;
   localparam int TMO     = 3000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          done_valid;
   logic          done_timeout;
   logic [7:0]    done_data;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dq_out;
   logic          fl_dq_oe;
   logic [7:0]    fl_dq_in = 8'h3C;
   logic          fl_ce_n;
   logic          fl_oe_n;
   logic          fl_we_n;

   always #10 clk = ~clk;

   pflash_job_master #(
      .AW(AW), .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HIGH), .OE_CYC(OE_C),
      .ID_WAIT_CYC(ID_WAIT), .TIMEOUT_CYC(TMO)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .done_valid(done_valid), .done_timeout(done_timeout), .done_data(done_data),
      .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
      .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural flash model and strobe monitor ----------------
   logic [7:0]  mem [int];
   logic [25:0] wq[$];
   int  cyc = 0;
   int  rd_count = 0;
   int  busy_left = 0;
   bit  tog = 1'b0;
   bit  id_mode = 1'b0;
   bit  prog_armed = 1'b0;
   bit  erase_armed = 1'b0;
   bit  prev_we = 1'b1;
   int  low_cnt = 0;
   int  high_cnt = 1000;
   int  oe_cnt = 0;
   int  last_rise = 0;
   int  id_gap = -1;
   bit  bad5 = 1'b0;
   bit  bad6 = 1'b0;
   logic [AW-1:0] cap_a;
   logic [7:0]    cap_d;
   logic [7:0]    cur_rv;

   function automatic logic [7:0] peek(input logic [AW-1:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
   endfunction

   task automatic apply_write(input logic [AW-1:0] a, input logic [7:0] d);
      int kill[$];
      if (prog_armed) begin
         mem[int'(a)] = peek(a) & d;
         prog_armed = 1'b0;
      end else if (a[14:0] == 15'h5555 && d == 8'hA0) prog_armed = 1'b1;
      else if (a[14:0] == 15'h5555 && d == 8'h80) erase_armed = 1'b1;
      else if (erase_armed && d == 8'h10) begin mem.delete(); erase_armed = 1'b0; end
      else if (erase_armed && d == 8'h30) begin
         foreach (mem[k]) if (k[17:13] == int'(a[17:13])) kill.push_back(k);
         foreach (kill[i]) mem.delete(kill[i]);
         erase_armed = 1'b0;
      end else if (a[14:0] == 15'h5555 && d == 8'h90) id_mode = 1'b1;
      else if (d == 8'hF0) id_mode = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!fl_we_n) begin
            if (prev_we) begin
               check(high_cnt >= WE_HIGH, "R4", "we high gap", high_cnt, WE_HIGH);
               cap_a = fl_addr; cap_d = fl_dq_out; low_cnt = 0; bad5 = 0; bad6 = 0;
            end
            low_cnt++;
            if (fl_addr != cap_a || fl_dq_out != cap_d) bad5 = 1'b1;
            if (!fl_oe_n || !fl_dq_oe) bad6 = 1'b1;
         end else begin
            if (!prev_we) begin
               check(low_cnt == WE_LOW, "R4", "we low width", low_cnt, WE_LOW);
               check(!bad5 && fl_dq_out == cap_d && fl_dq_oe, "R5", "addr/data hold", fl_dq_out, cap_d);
               check(!bad6, "R6", "oe high during write", bad6, 0);
               wq.push_back({cap_a, cap_d});
               apply_write(cap_a, cap_d);
               last_rise = cyc;
               high_cnt = 0;
            end
            high_cnt++;
         end
         prev_we = fl_we_n;
         if (!fl_oe_n) begin
            oe_cnt++;
            if (oe_cnt == 1) begin
               rd_count++;
               check(!fl_dq_oe, "R6", "driver off during read", fl_dq_oe, 0);
               if (id_mode) begin
                  id_gap = cyc - last_rise;
                  cur_rv = (fl_addr == 0) ? 8'hC1 : (fl_addr == 1) ? 8'h4D : 8'h00;
               end else cur_rv = peek(fl_addr);
               if (busy_left > 0) begin
                  cur_rv[6] = tog; tog = ~tog; busy_left--;
               end
            end
            fl_dq_in = (oe_cnt >= OE_C) ? cur_rv : 8'h3C;
         end else begin
            oe_cnt = 0;
            fl_dq_in = 8'h3C;
         end
      end
   end

   // ---------------- job driver ----------------
   bit  j_tmo;
   logic [7:0] j_data;
   int  j_cycles;
   bit  j_ready_seen;

   task automatic run_job(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int busy, input bit hold_valid);
      int lim;
      wq.delete(); rd_count = 0; busy_left = busy; tog = 1'b0; j_ready_seen = 1'b0;
      @(negedge clk);
      req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      if (hold_valid) begin req_op = 2'd2; req_data = 8'h00; end
      else req_valid = 1'b0;
      j_cycles = 0; lim = 0;
      while (!done_valid && lim < 20000) begin
         if (req_ready) j_ready_seen = 1'b1;
         @(negedge clk); j_cycles++; lim++;
      end
      check(done_valid, "WDOG", "job finished", done_valid, 1);
      req_valid = 1'b0;
      j_tmo = done_timeout; j_data = done_data;
      @(negedge clk);
   endtask

   function automatic int exp_reads(input int busy, input bit s);
      int prev = -1;
      for (int k = 1; k < 1000; k++) begin
         int b = (k <= busy) ? (k - 1) % 2 : int'(s);
         if (k > 1 && b == prev) return k;
         prev = b;
      end
      return -1;
   endfunction

   task automatic check_writes(input string req, input logic [25:0] exp[$]);
      check(wq.size() == exp.size(), req, "write count", wq.size(), exp.size());
      for (int i = 0; i < exp.size() && i < wq.size(); i++)
         check(wq[i] == exp[i], req, "write addr/data", wq[i], exp[i]);
   endtask

   function automatic logic [25:0] w(input int a, input int d);
      return {AW'(a), 8'(d)};
   endfunction

   initial begin
      logic [25:0] e[$];
      int idle_ok;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready && fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && !done_valid,
            "R1", "idle pins", {req_ready, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, done_valid}, 6'b111100);

      // R2 / R8 program, odd busy count
      run_job(2'd0, 18'h01234, 8'h5E, 3, 0);
      e = '{w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'hA0), w('h01234,'h5E)};
      check_writes("R2", e);
      check(rd_count == exp_reads(3, 1'b1), "R8", "poll reads", rd_count, exp_reads(3, 1'b1));
      check(!j_tmo && j_data == 8'h5E, "R8", "result", {j_tmo, j_data}, 9'h05E);
      check(!j_ready_seen, "R11", "ready low during job", j_ready_seen, 0);

      // R2 / R8 program, even busy count, bit6 clear
      run_job(2'd0, 18'h3A010, 8'hA5, 4, 0);
      e = '{w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'hA0), w('h3A010,'hA5)};
      check_writes("R2", e);
      check(rd_count == exp_reads(4, 1'b0), "R8", "poll reads", rd_count, exp_reads(4, 1'b0));
      check(j_data == 8'hA5, "R8", "read byte", j_data, 8'hA5);

      // R3 sector erase
      run_job(2'd1, 18'h3A010, 8'h00, 5, 0);
      e = '{w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'h80), w('h5555,'hAA), w('h2AAA,'h55), w('h3A010,'h30)};
      check_writes("R3", e);
      check(j_data == 8'hFF && !j_tmo, "R3", "sector erased", j_data, 8'hFF);
      check(rd_count == exp_reads(5, 1'b1), "R8", "poll reads", rd_count, exp_reads(5, 1'b1));

      // R3 chip erase
      run_job(2'd2, 18'h01234, 8'h00, 2, 0);
      e = '{w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'h80), w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'h10)};
      check_writes("R3", e);
      check(j_data == 8'hFF, "R3", "chip erased", j_data, 8'hFF);

      // R10 / R7 identification reads
      run_job(2'd3, 18'h00001, 8'h00, 0, 0);
      e = '{w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'h90), w('h00000,'hF0)};
      check_writes("R10", e);
      check(id_gap >= ID_WAIT, "R10", "pause before read", id_gap, ID_WAIT);
      check(rd_count == 1, "R10", "single read", rd_count, 1);
      check(j_data == 8'h4D, "R7", "code at 1", j_data, 8'h4D);
      run_job(2'd3, 18'h00000, 8'h00, 0, 0);
      check(j_data == 8'hC1, "R7", "code at 0", j_data, 8'hC1);
      check(!id_mode, "R10", "exit written", id_mode, 0);

      // R11 request inputs changed mid-job are ignored
      run_job(2'd0, 18'h00077, 8'h12, 1, 1);
      e = '{w('h5555,'hAA), w('h2AAA,'h55), w('h5555,'hA0), w('h00077,'h12)};
      check_writes("R11", e);
      idle_ok = 1;
      repeat (30) begin @(negedge clk); if (!fl_ce_n) idle_ok = 0; end
      check(idle_ok == 1 && req_ready, "R11", "no job after drop", idle_ok, 1);

      // R9 never-ending toggle
      run_job(2'd0, 18'h00100, 8'h00, 1000000, 0);
      check(j_tmo, "R9", "timeout flag", j_tmo, 1);
      check(j_cycles >= TMO, "R9", "timeout length", j_cycles, TMO);
      busy_left = 0;
      check(req_ready && fl_ce_n, "R1", "idle after timeout", {req_ready, fl_ce_n}, 2'b11);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule